// File: doc/BRIEF.md
# Time-Shared Serial Audio DAC Sequencer

This block feeds one serial-input 16-bit audio converter that serves both stereo channels in turn. A producer hands over a left and a right two's-complement sample together through a valid/ready handshake. The block shifts the left word out first, most significant bit first, on a bit clock it derives from the system clock. It marks the end of the word with a latch pulse, waits a fixed settling time, and then pulses the left sample/hold switch. The right word follows through the same steps and ends with a pulse on the right switch.

Between words the bit clock rests low. The latch pulse lies in that gap, so the latch line is low for the whole of every word and high for a full bit-clock period before it falls. The bit-clock half period, the settling delay and the switch pulse width are parameters counted in system clocks. With the defaults at 250 MHz, each bit-clock phase lasts 48 ns and the settling delay is 1.5 µs.

Top module: `tsdac_ctrl`

## Requirements
- R1: `in_ready` is high exactly while the block is idle. A pair is taken on a clock where `in_valid` and `in_ready` are both high. `in_valid` and the sample inputs have no effect while the block is busy. `in_ready` stays low until the right channel's switch pulse has ended.
- R2: Each word is DATA_W (16) bits, sent most significant bit first, one bit per rising edge of `dac_bclk`. The bits collected at those edges equal the captured sample unchanged, so two's-complement values pass as is.
- R3: Within a word, each high phase and each low phase of `dac_bclk` between rising edges lasts exactly HALF_DIV system clocks. Between words `dac_bclk` stays low.
- R4: `dac_data` never changes while `dac_bclk` is high, and never in the cycle where `dac_bclk` rises. Each bit is therefore stable for HALF_DIV clocks on each side of its capturing edge.
- R5: `dac_le` rises only after the last rising edge of a word and after `dac_bclk` has fallen. It then stays high for exactly 2*HALF_DIV clocks, and `dac_bclk` stays low during that time.
- R6: Exactly DATA_W rising edges of `dac_bclk` occur between one fall of `dac_le` and the next rise of `dac_le`, so the latch line is low through the whole of each word.
- R7: Within a pair, the left word is sent first and the right word second. The first switch pulse after a pair is accepted is on `sh_left`; the second is on `sh_right`.
- R8: The switch output of a channel rises exactly SETTLE_CYC system clocks after `dac_le` falls at the end of that channel's word.
- R9: Each switch pulse lasts exactly HOLD_CYC clocks, and `sh_left` and `sh_right` are never high together.
- R10: Both switch outputs are low whenever `dac_le` or `dac_bclk` is high.
- R11: The asynchronous active-low reset drives all outputs low and `in_ready` high. A reset in the middle of a word abandons that word, and the next accepted pair goes out in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a sample pair |
| in_ready | output | 1 | Block is idle and takes a pair |
| in_left | input | DATA_W | Left-channel sample, two's complement |
| in_right | input | DATA_W | Right-channel sample, two's complement |
| dac_bclk | output | 1 | Bit clock to the converter; data captured on its rising edge |
| dac_data | output | 1 | Serial data, most significant bit first |
| dac_le | output | 1 | Latch pulse; its falling edge loads the word |
| sh_left | output | 1 | Left sample/hold switch control |
| sh_right | output | 1 | Right sample/hold switch control |

## Verification
A behavioural model of the converter's serial port collects the bits at each rising bit-clock edge and stores a word at every latch fall. Both are compared with the accepted samples. The sample pairs include all-zero against all-one, the two most extreme signed values, alternating bit patterns, and words where only the top or bottom bit differs. These tell a correct most-significant-first order from a reversed or shifted one, and a correct left/right order from a swapped one. Further directed runs cover stray valid requests with altered data while the block is busy, and a reset in the middle of a word followed by a clean pair. Throughout, the model measures phase widths, the latch pulse, the settling delay and the switch pulse widths in system clocks.

// File: rtl/tsdac_pkg.sv
package tsdac_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SHIFT  = 3'd1,
    PH_LATCH  = 3'd2,
    PH_SETTLE = 3'd3,
    PH_STROBE = 3'd4
  } phase_e;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  localparam int unsigned NUM_CH = 2;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/tsdac_interval.sv
module tsdac_interval #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign expire = run && (cnt_q == (limit - CNT_W'(1)));

  always_comb begin
    cnt_d = cnt_q;
    if (restart)  cnt_d = '0;
    else if (run) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tsdac_pair_buf.sv
module tsdac_pair_buf
  import tsdac_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] left_in,
  input  logic [DATA_W-1:0] right_in,
  input  chan_e             sel,
  output logic [DATA_W-1:0] word
);

  logic [DATA_W-1:0] smp_in [NUM_CH];
  logic [DATA_W-1:0] held   [NUM_CH];

  assign smp_in[0] = left_in;
  assign smp_in[1] = right_in;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q, slot_d;

    always_comb begin
      slot_d = slot_q;
      if (capture) slot_d = smp_in[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else        slot_q <= slot_d;
    end

    assign held[g] = slot_q;
  end

  assign word = held[sel];

endmodule

// File: rtl/tsdac_shifter.sv
module tsdac_shifter #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              advance,
  output logic              top_bit
);

  logic [DATA_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load)         sr_d = load_val;
    else if (advance) sr_d = {sr_q[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign top_bit = sr_q[DATA_W-1];

endmodule

// File: rtl/tsdac_ctrl.sv
module tsdac_ctrl
  import tsdac_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned HALF_DIV   = 12,
  parameter int unsigned SETTLE_CYC = 375,
  parameter int unsigned HOLD_CYC   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  output logic              dac_bclk,
  output logic              dac_data,
  output logic              dac_le,
  output logic              sh_left,
  output logic              sh_right
);

  localparam int unsigned LATCH_CYC = 2 * HALF_DIV;
  localparam int unsigned TW        = $clog2(max3(LATCH_CYC, SETTLE_CYC, HOLD_CYC) + 1);
  localparam int unsigned BW        = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  phase_e        ph_q, ph_d;
  chan_e         ch_q, ch_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          bclk_q, bclk_d;
  logic          le_q, le_d;
  logic          swl_q, swl_d;
  logic          swr_q, swr_d;

  logic          accept;
  logic          expire;
  logic [TW-1:0] limit;
  logic          load_word;
  logic          shift_adv;
  chan_e         buf_sel;
  logic [DATA_W-1:0] cur_word;

  assign accept = in_valid && (ph_q == PH_IDLE);

  always_comb begin
    case (ph_q)
      PH_SHIFT:  limit = TW'(HALF_DIV);
      PH_LATCH:  limit = TW'(LATCH_CYC);
      PH_SETTLE: limit = TW'(SETTLE_CYC);
      PH_STROBE: limit = TW'(HOLD_CYC);
      default:   limit = TW'(1);
    endcase
  end

  tsdac_interval #(.CNT_W(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ph_q != PH_IDLE),
    .restart (accept || expire),
    .limit   (limit),
    .expire  (expire)
  );

  assign load_word = accept || ((ph_q == PH_STROBE) && expire && (ch_q == CH_LEFT));
  assign buf_sel   = accept ? CH_LEFT : (load_word ? CH_RIGHT : ch_q);
  assign shift_adv = (ph_q == PH_SHIFT) && expire && bclk_q && (bit_q != LAST_BIT);

  tsdac_pair_buf #(.DATA_W(DATA_W)) u_pair (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (accept),
    .left_in  (in_left),
    .right_in (in_right),
    .sel      (buf_sel),
    .word     (cur_word)
  );

  // Left word loads straight from the inputs on accept; the right one from the buffer.
  tsdac_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_word),
    .load_val (accept ? in_left : cur_word),
    .advance  (shift_adv),
    .top_bit  (dac_data)
  );

  always_comb begin
    ph_d   = ph_q;
    ch_d   = ch_q;
    bit_d  = bit_q;
    bclk_d = bclk_q;
    le_d   = le_q;
    swl_d  = swl_q;
    swr_d  = swr_q;
    case (ph_q)
      PH_IDLE: begin
        if (accept) begin
          ph_d   = PH_SHIFT;
          ch_d   = CH_LEFT;
          bit_d  = '0;
          bclk_d = 1'b0;
        end
      end
      PH_SHIFT: begin
        if (expire) begin
          if (!bclk_q) begin
            bclk_d = 1'b1;
          end else begin
            bclk_d = 1'b0;
            if (bit_q == LAST_BIT) begin
              ph_d = PH_LATCH;
              le_d = 1'b1;
            end else begin
              bit_d = bit_q + BW'(1);
            end
          end
        end
      end
      PH_LATCH: begin
        if (expire) begin
          le_d = 1'b0;
          ph_d = PH_SETTLE;
        end
      end
      PH_SETTLE: begin
        if (expire) begin
          ph_d = PH_STROBE;
          if (ch_q == CH_LEFT) swl_d = 1'b1;
          else                 swr_d = 1'b1;
        end
      end
      PH_STROBE: begin
        if (expire) begin
          swl_d = 1'b0;
          swr_d = 1'b0;
          if (ch_q == CH_LEFT) begin
            ch_d  = CH_RIGHT;
            ph_d  = PH_SHIFT;
            bit_d = '0;
          end else begin
            ph_d = PH_IDLE;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      ch_q   <= CH_LEFT;
      bit_q  <= '0;
      bclk_q <= 1'b0;
      le_q   <= 1'b0;
      swl_q  <= 1'b0;
      swr_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      ch_q   <= ch_d;
      bit_q  <= bit_d;
      bclk_q <= bclk_d;
      le_q   <= le_d;
      swl_q  <= swl_d;
      swr_q  <= swr_d;
    end
  end

  assign in_ready = (ph_q == PH_IDLE);
  assign dac_bclk = bclk_q;
  assign dac_le   = le_q;
  assign sh_left  = swl_q;
  assign sh_right = swr_q;

  // R1: once a pair is taken the block stays busy
  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R4: serial data held while the bit clock is high, including its rising cycle
  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dac_bclk |-> $stable(dac_data));

  // R5: the bit clock rests while the latch line is high
  p_le_clock_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dac_le |-> !dac_bclk);

  // R5: latch line only rises out of the shifting phase
  p_le_rise_after_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_le) |-> ($past(ph_q) == PH_SHIFT));

  // R9: switches mutually exclusive
  p_switch_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sh_left && sh_right));

  // R10: switches open while the converter is being loaded or latched
  p_switch_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_le || dac_bclk) |-> !(sh_left || sh_right));

endmodule

// File: tb/test_tsdac_ctrl.sv
`timescale 1ns/1ps
module test_tsdac_ctrl;

  localparam int unsigned DW     = 16;
  localparam int unsigned HALF   = 12;
  localparam int unsigned SETTLE = 375;
  localparam int unsigned HOLD   = 40;
  localparam int unsigned NVEC   = 6;

  // {left sample, right sample}; the serial model must receive exactly these words
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0000_FFFF,
    32'h8000_7FFF,
    32'hA5A5_5A5A,
    32'h0001_8001,
    32'h1234_FEDC,
    32'hFFFF_0000
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_left = '0;
  logic [DW-1:0] in_right = '0;
  logic          dac_bclk, dac_data, dac_le, sh_left, sh_right;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  tsdac_ctrl #(.DATA_W(DW), .HALF_DIV(HALF), .SETTLE_CYC(SETTLE), .HOLD_CYC(HOLD)) i_tsdac_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .dac_bclk(dac_bclk), .dac_data(dac_data),
    .dac_le(dac_le), .sh_left(sh_left), .sh_right(sh_right)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural converter serial port plus timing monitor, sampled on the falling edge
  logic          p_bclk, p_data, p_le, p_swl, p_swr;
  int            bclk_run, le_run, sw_run, since_fall, rises, parity, nrx;
  bit            hi_dirty, fell_once;
  logic [DW-1:0] rx;
  logic [DW-1:0] rxw [64];

  always @(negedge clk) begin
    if (!rst_n) begin
      p_bclk = 0; p_data = 0; p_le = 0; p_swl = 0; p_swr = 0;
      bclk_run = 0; le_run = 0; sw_run = 0; since_fall = 0;
      rises = 0; parity = 0; hi_dirty = 0; fell_once = 0; rx = '0;
    end else begin
      since_fall++;
      if (dac_bclk && !p_bclk) begin
        check(dac_data == p_data, "R4 data changed at rising edge", dac_data, p_data);
        if (rises > 0) check(bclk_run == HALF, "R3 low phase width", bclk_run, HALF);
        rx = {rx[DW-2:0], dac_data};
        rises++;
      end
      if (dac_bclk && p_bclk && dac_data != p_data) hi_dirty = 1;
      if (!dac_bclk && p_bclk) begin
        check(bclk_run == HALF, "R3 high phase width", bclk_run, HALF);
        check(!hi_dirty, "R4 data changed while clock high", hi_dirty, 0);
        hi_dirty = 0;
      end
      bclk_run = (dac_bclk != p_bclk) ? 1 : bclk_run + 1;

      if (dac_le && !p_le) begin
        check(rises == DW, "R6 rising edges per word", rises, DW);
        check(!dac_bclk, "R5 clock low at latch rise", dac_bclk, 0);
        check(!sh_left && !sh_right, "R10 switches low at latch rise", {sh_left, sh_right}, 0);
      end
      if (!dac_le && p_le) begin
        check(le_run == 2 * HALF, "R5 latch high width", le_run, 2 * HALF);
        if (nrx < 64) rxw[nrx] = rx;
        nrx++;
        rises = 0;
        since_fall = 0;
        fell_once = 1;
      end
      le_run = (dac_le != p_le) ? 1 : le_run + 1;

      if ((sh_left && !p_swl) || (sh_right && !p_swr)) begin
        check(fell_once && since_fall == SETTLE, "R8 settle delay", since_fall, SETTLE);
        check(parity == 0 ? (sh_left && !sh_right) : (sh_right && !sh_left),
              "R7 switch channel order", {sh_left, sh_right}, parity == 0 ? 2 : 1);
        parity ^= 1;
      end
      if ((!sh_left && p_swl) || (!sh_right && p_swr))
        check(sw_run == HOLD, "R9 switch pulse width", sw_run, HOLD);
      sw_run = ((sh_left | sh_right) != (p_swl | p_swr)) ? 1 : sw_run + 1;
      if (sh_left && sh_right) check(0, "R9 both switches high", 3, 0);

      p_bclk = dac_bclk; p_data = dac_data; p_le = dac_le; p_swl = sh_left; p_swr = sh_right;
    end
  end

  task automatic wait_ready();
    do @(negedge clk); while (!in_ready);
  endtask

  task automatic run_pair(input logic [DW-1:0] l, input logic [DW-1:0] r, input bit stray);
    int base;
    wait_ready();
    base = nrx;
    in_valid = 1; in_left = l; in_right = r;
    @(negedge clk);
    check(!in_ready, "R1 busy after accept", in_ready, 0);
    if (stray) begin
      in_left = ~l; in_right = ~r;
      repeat (300) @(negedge clk);
      check(!in_ready, "R1 ready low while busy", in_ready, 0);
    end
    in_valid = 0;
    wait_ready();
    check(nrx == base + 2, "R1 words per pair", nrx - base, 2);
    check(rxw[base] == l, "R2 R7 left word first", rxw[base], l);
    check(rxw[base + 1] == r, "R2 R7 right word second", rxw[base + 1], r);
    check(!sh_left && !sh_right, "R1 switches done when ready", {sh_left, sh_right}, 0);
  endtask

  task automatic check_rest(input string req);
    check(in_ready && !dac_bclk && !dac_data && !dac_le && !sh_left && !sh_right, req,
          {in_ready, dac_bclk, dac_data, dac_le, sh_left, sh_right}, 6'b100000);
  endtask

  initial begin
    nrx = 0;
    repeat (3) @(negedge clk);
    check_rest("R11 reset outputs");
    rst_n = 1;
    @(negedge clk);
    check_rest("R11 idle after reset");

    for (int i = 0; i < NVEC; i++)
      run_pair(VEC[i][31:16], VEC[i][15:0], i == 2);

    // R11: reset in the middle of a word
    wait_ready();
    in_valid = 1; in_left = 16'h7E81; in_right = 16'h0F0F;
    @(negedge clk);
    in_valid = 0;
    repeat (100) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check_rest("R11 reset mid-word");
    rst_n = 1;
    repeat (50) @(negedge clk);
    check_rest("R11 idle after mid-word reset");
    run_pair(16'hC3A1, 16'h1C5E, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule